// File: doc/BRIEF.md
# Block-Erase Flash Memory Emulator

This block models a small non-volatile memory with flash-style write rules: 4 blocks of 16 bytes each, driven through a command port with a busy handshake. A host issues one of three commands: read a byte, program a byte, or erase a whole block. Reads finish in one clock. Programs and erases keep `busy` high for a fixed number of clocks. Programs hold busy for 8 clocks and erases for 64. While busy is high, new commands are dropped.

Programming can only turn ones into zeros, and only a byte that still reads 0xFF may be programmed. Any other program attempt raises an error pulse and changes nothing. Erasing sets every byte of one block back to 0xFF. Each block keeps its own erase count. After 200 completed erases, that block refuses further erases with a wear-out error pulse.

The 6-bit address splits into a block number in bits [5:4] and a byte offset in bits [3:0].

Top module: `flash_emu`

## Requirements
- R1: After reset, `busy`, `rd_valid`, `prog_err` and `wear_err` are 0 and every byte reads 0xFF.
- R2: A read (`cmd_op` = 2'b00) accepted while `busy` is low pulses `rd_valid` for one cycle on the next clock, with `rd_data` holding the byte at `cmd_addr`. The block is `cmd_addr[5:4]` and the byte offset is `cmd_addr[3:0]`.
- R3: A program (`cmd_op` = 2'b01) to a byte that reads 0xFF starts on the next clock. `busy` then stays high for exactly 8 cycles. After that the byte reads `cmd_wdata` and every other byte is unchanged.
- R4: A program to a byte that is not 0xFF pulses `prog_err` on the next clock, leaves `busy` low and leaves the byte unchanged.
- R5: An erase (`cmd_op` = 2'b10) starts on the next clock and holds `busy` high for exactly 64 cycles. After that all 16 bytes of the block selected by `cmd_addr[5:4]` read 0xFF, bytes of other blocks are unchanged, and the erased bytes can be programmed again.
- R6: While `busy` is high, every command is dropped: a read gives no `rd_valid`, and a program or erase changes no byte.
- R7: Each block counts its completed erases in 8 bits. An erase of a block whose count has reached 200 pulses `wear_err` on the next clock, leaves `busy` low, and leaves the block's contents unchanged. Other blocks are still erased normally.
- R8: `cmd_op` = 2'b11 is ignored: no busy, no `rd_valid`, no error pulse, and no change to any byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 read, 01 program, 10 erase, 11 ignored |
| cmd_addr | input | 6 | Block in [5:4], byte offset in [3:0] |
| cmd_wdata | input | 8 | Byte value for a program |
| busy | output | 1 | Program or erase in progress; commands dropped |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` is valid |
| rd_data | output | 8 | Byte returned by the last accepted read |
| prog_err | output | 1 | One-cycle pulse: program refused, target not erased |
| wear_err | output | 1 | One-cycle pulse: erase refused, block worn out |

## Verification
The bench tries to reprogram a byte that is already written. A design that skipped the erased check would either overwrite the byte or AND the new value into it, and the read-back would show it. It sends reads and writes while busy is high. A design that accepted them would produce an unexpected read result or change a neighbouring byte. It erases one block and checks bytes both inside and outside that block, so an erase that hit the wrong block or only one byte would show up. It drives one block to exactly 200 erases and then tries a 201st. An off-by-one limit would either refuse the 200th erase or wipe a freshly programmed byte on the 201st, and the check on a second block catches a wear count shared between blocks.

// File: rtl/flash_emu_pkg.sv
package flash_emu_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_PROG  = 2'b01,
        OP_ERASE = 2'b10,
        OP_NOP   = 2'b11
    } flash_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_PROG  = 2'b01,
        ST_ERASE = 2'b10
    } flash_state_e;

endpackage

// File: rtl/flash_emu_timer.sv
// Down-counter that times one program or erase operation.
module flash_emu_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } timer_t;

    timer_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (start) begin
            t_d.cnt = load_val;
        end else if (t_q.cnt != '0) begin
            t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign done = (t_q.cnt == CNT_W'(1));

    // R3 / R5: the length is loaded on the start edge.
    p_load_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (t_q.cnt == $past(load_val)));

    // R6: a new operation never starts while one is still being timed.
    p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (t_q.cnt == '0));

endmodule

// File: rtl/flash_emu_array.sv
// Byte storage and per-block erase counters.
module flash_emu_array #(
    parameter int NUM_BLOCKS  = 4,
    parameter int BLOCK_BYTES = 16,
    parameter int DATA_W      = 8,
    parameter int WEAR_W      = 8,
    parameter int WEAR_LIMIT  = 200,
    localparam int DEPTH  = NUM_BLOCKS * BLOCK_BYTES,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int BLK_W  = $clog2(NUM_BLOCKS),
    localparam int OFS_W  = ADDR_W - BLK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] look_addr,
    output logic [DATA_W-1:0] look_byte,
    output logic [WEAR_W-1:0] look_wear,
    input  logic              prog_en,
    input  logic              erase_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0]      mem;
        logic [NUM_BLOCKS-1:0][WEAR_W-1:0] wear;
    } array_t;

    array_t a_d, a_q;

    logic [BLK_W-1:0] wr_blk;
    logic [BLK_W-1:0] look_blk;

    assign wr_blk   = wr_addr[ADDR_W-1:OFS_W];
    assign look_blk = look_addr[ADDR_W-1:OFS_W];

    always_comb begin
        a_d = a_q;
        if (prog_en) begin
            // Programming can only clear bits.
            a_d.mem[wr_addr] = a_q.mem[wr_addr] & wr_data;
        end
        if (erase_en) begin
            for (int i = 0; i < BLOCK_BYTES; i++) begin
                a_d.mem[{wr_blk, i[OFS_W-1:0]}] = '1;
            end
            if (a_q.wear[wr_blk] != WEAR_W'(WEAR_LIMIT)) begin
                a_d.wear[wr_blk] = a_q.wear[wr_blk] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q.mem  <= '1;
            a_q.wear <= '0;
        end else begin
            a_q <= a_d;
        end
    end

    assign look_byte = a_q.mem[look_addr];
    assign look_wear = a_q.wear[look_blk];

    // R4: only erased bytes are ever programmed.
    p_prog_on_erased_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |-> (a_q.mem[wr_addr] == '1));

    // R5: the addressed byte reads all ones after an erase.
    p_erase_fills_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |=> (a_q.mem[$past(wr_addr)] == '1));

    // R7: no erase count ever passes the limit.
    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_wear_chk
        p_wear_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
            a_q.wear[b] <= WEAR_W'(WEAR_LIMIT));
    end

endmodule

// File: rtl/flash_emu_ctrl.sv
// Command acceptance, rule checks and operation sequencing.
module flash_emu_ctrl
    import flash_emu_pkg::*;
#(
    parameter int ADDR_W       = 6,
    parameter int DATA_W       = 8,
    parameter int WEAR_W       = 8,
    parameter int WEAR_LIMIT   = 200,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 64,
    parameter int TIMER_W      = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic [DATA_W-1:0]  cmd_wdata,
    input  logic [DATA_W-1:0]  look_byte,
    input  logic [WEAR_W-1:0]  look_wear,
    input  logic               timer_done,
    output logic               busy,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data,
    output logic               prog_err,
    output logic               wear_err,
    output logic               timer_start,
    output logic [TIMER_W-1:0] timer_load,
    output logic               prog_en,
    output logic               erase_en,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [DATA_W-1:0]  wr_data
);

    typedef struct packed {
        flash_state_e      st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              rd_valid;
        logic [DATA_W-1:0] rd_data;
        logic              prog_err;
        logic              wear_err;
    } ctrl_t;

    ctrl_t     c_d, c_q;
    flash_op_e op;

    assign op = flash_op_e'(cmd_op);

    always_comb begin
        c_d          = c_q;
        c_d.rd_valid = 1'b0;
        c_d.prog_err = 1'b0;
        c_d.wear_err = 1'b0;
        timer_start  = 1'b0;
        timer_load   = '0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    unique case (op)
                        OP_READ: begin
                            c_d.rd_valid = 1'b1;
                            c_d.rd_data  = look_byte;
                        end
                        OP_PROG: begin
                            if (look_byte != '1) begin
                                c_d.prog_err = 1'b1;
                            end else begin
                                c_d.st      = ST_PROG;
                                c_d.addr    = cmd_addr;
                                c_d.wdata   = cmd_wdata;
                                timer_start = 1'b1;
                                timer_load  = TIMER_W'(PROG_CYCLES);
                            end
                        end
                        OP_ERASE: begin
                            if (look_wear >= WEAR_W'(WEAR_LIMIT)) begin
                                c_d.wear_err = 1'b1;
                            end else begin
                                c_d.st      = ST_ERASE;
                                c_d.addr    = cmd_addr;
                                timer_start = 1'b1;
                                timer_load  = TIMER_W'(ERASE_CYCLES);
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_PROG, ST_ERASE: begin
                if (timer_done) begin
                    c_d.st = ST_IDLE;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.st       <= ST_IDLE;
            c_q.addr     <= '0;
            c_q.wdata    <= '0;
            c_q.rd_valid <= 1'b0;
            c_q.rd_data  <= '0;
            c_q.prog_err <= 1'b0;
            c_q.wear_err <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy     = (c_q.st != ST_IDLE);
    assign rd_valid = c_q.rd_valid;
    assign rd_data  = c_q.rd_data;
    assign prog_err = c_q.prog_err;
    assign wear_err = c_q.wear_err;
    assign prog_en  = (c_q.st == ST_PROG) && timer_done;
    assign erase_en = (c_q.st == ST_ERASE) && timer_done;
    assign wr_addr  = c_q.addr;
    assign wr_data  = c_q.wdata;

    // R6: a command offered while busy never produces read data.
    p_read_refused_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> !rd_valid);

    // R4: a refused program does not start an operation.
    p_prog_err_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prog_err |-> !busy);

    // R7: a refused erase does not start an operation.
    p_wear_err_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wear_err |-> !busy);

    // R3 / R5: busy only drops when the storage is committed.
    p_busy_ends_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(prog_en || erase_en));

    // R8: the unused opcode has no visible effect.
    p_nop_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && cmd_op == 2'b11)
            |=> (!busy && !rd_valid && !prog_err && !wear_err));

endmodule

// File: rtl/flash_emu.sv
// Top: small block-erase flash memory model with command/busy port.
module flash_emu #(
    parameter int NUM_BLOCKS   = 4,
    parameter int BLOCK_BYTES  = 16,
    parameter int DATA_W       = 8,
    parameter int WEAR_W       = 8,
    parameter int WEAR_LIMIT   = 200,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 64,
    localparam int ADDR_W  = $clog2(NUM_BLOCKS * BLOCK_BYTES),
    localparam int TIMER_W = $clog2(((PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              prog_err,
    output logic              wear_err
);

    logic [DATA_W-1:0]  look_byte;
    logic [WEAR_W-1:0]  look_wear;
    logic               timer_start;
    logic [TIMER_W-1:0] timer_load;
    logic               timer_done;
    logic               prog_en;
    logic               erase_en;
    logic [ADDR_W-1:0]  wr_addr;
    logic [DATA_W-1:0]  wr_data;

    flash_emu_ctrl #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .WEAR_W      (WEAR_W),
        .WEAR_LIMIT  (WEAR_LIMIT),
        .PROG_CYCLES (PROG_CYCLES),
        .ERASE_CYCLES(ERASE_CYCLES),
        .TIMER_W     (TIMER_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_addr   (cmd_addr),
        .cmd_wdata  (cmd_wdata),
        .look_byte  (look_byte),
        .look_wear  (look_wear),
        .timer_done (timer_done),
        .busy       (busy),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .prog_err   (prog_err),
        .wear_err   (wear_err),
        .timer_start(timer_start),
        .timer_load (timer_load),
        .prog_en    (prog_en),
        .erase_en   (erase_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    flash_emu_timer #(
        .CNT_W(TIMER_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (timer_start),
        .load_val(timer_load),
        .done    (timer_done)
    );

    flash_emu_array #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLOCK_BYTES(BLOCK_BYTES),
        .DATA_W     (DATA_W),
        .WEAR_W     (WEAR_W),
        .WEAR_LIMIT (WEAR_LIMIT)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .look_addr(cmd_addr),
        .look_byte(look_byte),
        .look_wear(look_wear),
        .prog_en  (prog_en),
        .erase_en (erase_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    // R2: read data is only presented when no operation is running.
    p_read_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !busy);

endmodule

// File: tb/flash_emu_test.sv
`timescale 1ns/1ps
module flash_emu_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [5:0] cmd_addr = '0;
    logic [7:0] cmd_wdata = '0;
    logic       busy, rd_valid, prog_err, wear_err;
    logic [7:0] rd_data;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    logic [7:0] model [64];
    int         wear_model [4];
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #10 clk = ~clk;

    flash_emu uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data), .prog_err(prog_err),
        .wear_err(wear_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: every read result is compared against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                total++;
                fails++;
                $display("FAIL R6 unexpected read data: actual %0d expected none", rd_data);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_data == e, t, "read data", rd_data, e);
            end
        end
    end

    task automatic send(input logic [1:0] op, input logic [5:0] addr, input logic [7:0] data);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = addr;
        cmd_wdata = data;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_read(input logic [5:0] addr, input string req);
        exp_q.push_back(model[addr]);
        tag_q.push_back(req);
        send(2'b00, addr, 8'h00);
    endtask

    task automatic wait_busy(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_prog(input logic [5:0] addr, input logic [7:0] data);
        bit ok;
        int n;
        ok = (model[addr] == 8'hFF);
        send(2'b01, addr, data);
        if (ok) begin
            check(prog_err == 1'b0, "R3", "prog_err on erased byte", prog_err, 0);
            wait_busy(n);
            check(n == 8, "R3", "program busy cycles", n, 8);
            model[addr] = data;
        end else begin
            check(prog_err == 1'b1, "R4", "prog_err on written byte", prog_err, 1);
            check(busy == 1'b0, "R4", "busy after refused program", busy, 0);
        end
    endtask

    task automatic do_erase(input int blk);
        bit ok;
        int n;
        ok = (wear_model[blk] < 200);
        send(2'b10, 6'(blk * 16 + 3), 8'h00);
        if (ok) begin
            check(wear_err == 1'b0, "R5", "wear_err on erase", wear_err, 0);
            wait_busy(n);
            check(n == 64, "R5", "erase busy cycles", n, 64);
            for (int i = 0; i < 16; i++) model[blk * 16 + i] = 8'hFF;
            wear_model[blk]++;
        end else begin
            check(wear_err == 1'b1, "R7", "wear_err at limit", wear_err, 1);
            check(busy == 1'b0, "R7", "busy after refused erase", busy, 0);
        end
    endtask

    initial begin
        int n;
        for (int i = 0; i < 64; i++) model[i] = 8'hFF;
        for (int b = 0; b < 4; b++) wear_model[b] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        check(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);
        check(prog_err == 1'b0 && wear_err == 1'b0, "R1", "error flags after reset",
              prog_err | wear_err, 0);
        do_read(6'd0, "R1");
        do_read(6'd17, "R1");
        do_read(6'd63, "R1");

        // R2 / R3: programs and read-back across blocks
        do_prog(6'd5, 8'h3C);
        do_prog(6'h1A, 8'hA5);
        do_prog(6'd63, 8'h00);
        do_read(6'd5, "R2");
        do_read(6'h1A, "R2");
        do_read(6'd63, "R2");
        do_read(6'd4, "R3");
        do_read(6'd6, "R3");

        // R4: reprogramming a written byte
        do_prog(6'd5, 8'h00);
        do_read(6'd5, "R4");

        // R6: commands while busy are dropped
        send(2'b01, 6'd8, 8'h11);
        check(busy == 1'b1, "R6", "busy after program start", busy, 1);
        send(2'b00, 6'd5, 8'h00);
        send(2'b01, 6'd9, 8'h22);
        send(2'b10, 6'd0, 8'h00);
        wait_busy(n);
        model[8] = 8'h11;
        check(busy == 1'b0, "R6", "busy after program done", busy, 0);
        do_read(6'd9, "R6");
        do_read(6'd8, "R6");
        do_read(6'd5, "R6");

        // R8: unused opcode
        send(2'b11, 6'd5, 8'h00);
        check(busy == 1'b0 && prog_err == 1'b0 && wear_err == 1'b0, "R8",
              "no activity on nop", busy | prog_err | wear_err, 0);
        do_read(6'd5, "R8");

        // R5: block erase, other block untouched, rewrite allowed
        do_erase(0);
        do_read(6'd5, "R5");
        do_read(6'd8, "R5");
        do_read(6'h1A, "R5");
        do_prog(6'd5, 8'h77);
        do_read(6'd5, "R5");

        // R7: wear limit on block 2
        for (int k = 0; k < 200; k++) do_erase(2);
        do_prog(6'h25, 8'h42);
        do_erase(2);
        do_read(6'h25, "R7");
        do_erase(3);
        do_read(6'd63, "R7");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2", "reads left without result", exp_q.size(), 0);

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog: run did not end, actual 1 expected 0");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule